// File: doc/BRIEF.md
# Exception Pending Control Register

This block is one 32-bit memory-mapped control and status word. It holds the pending state of three system exceptions: a non-maskable interrupt (NMI), a deferred service call and a periodic tick. Software raises each flag with a write-one set bit. The deferred-service and tick flags also have a write-one clear bit. The core clears a flag by pulsing the matching acknowledge input when it enters that handler. An NMI raised again while its handler runs latches the flag a second time.

A read also returns two values that come from elsewhere: the vector number of the active exception and the vector number of the highest-priority pending exception. Both are inputs and are passed through combinationally. A debug interrupt indication is returned as well, and it is only visible while debug mode is on. Only privileged accesses reach the register. An unprivileged access changes no state, reads zero and pulses an error output.

Top module: `exc_pend_reg`

## Requirements
- R1: After reset all three pending outputs are 0 and `bus_err` is 0.
- R2: A privileged write at offset 0xD04 with bit 31 set makes `nmi_pend` 1 from the next cycle. Bit 31 of a read returns that flag.
- R3: Bit 28 written as 1 sets `svc_pend`, and bit 27 written as 1 clears it. Writing both bits as 1 in one write leaves the flag unchanged. Bit 28 of a read returns the flag.
- R4: Bit 26 written as 1 sets `tick_pend`, and bit 25 written as 1 clears it. Writing both bits as 1 in one write leaves the flag unchanged. Bit 26 of a read returns the flag.
- R5: The write-only bits 27 and 25 always read 0. The reserved bits 30, 29 and 24 always read 0, and so do bits 22:21 and 11:9.
- R6: An `nmi_ack` pulse clears `nmi_pend`, and this wins over a software set in the same cycle. An `nmi_raise` pulse sets `nmi_pend`, and this wins over an acknowledge in the same cycle.
- R7: A `svc_ack` or `tick_ack` pulse clears its flag, and this wins over a software set of that flag in the same cycle.
- R8: Read bit 23 equals `dbg_irq` while `dbg_mode` is 1 and reads 0 while `dbg_mode` is 0.
- R9: Read bits 8:0 return `act_vec` and read bits 20:12 return `pend_vec`, both taken in the same cycle as the read.
- R10: A write at any other offset changes no flag. A read at any other offset, or with `bus_rd` low, returns 0.
- R11: An access with `bus_priv` low changes no flag and reads 0. It also drives `bus_err` high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 12 | Byte offset within the block's window |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | One-cycle error after an unprivileged access |
| nmi_raise | input | 1 | New NMI assertion from the NMI source |
| nmi_ack | input | 1 | Core entered the NMI handler |
| svc_ack | input | 1 | Core entered the deferred-service handler |
| tick_ack | input | 1 | Core entered the tick handler |
| dbg_mode | input | 1 | Core is in debug mode |
| dbg_irq | input | 1 | Debug interrupt condition |
| act_vec | input | 9 | Active exception vector number |
| pend_vec | input | 9 | Highest-priority pending vector number |
| nmi_pend | output | 1 | NMI pending |
| svc_pend | output | 1 | Deferred service pending |
| tick_pend | output | 1 | Tick pending |

## Verification
The bench builds the block with its default parameters: a 12-bit offset, the register at 0xD04 and 9-bit vector fields. With these values an all-ones active vector and a patterned pending vector show that the vector fields fill their bit ranges fully and do not spill into the reserved bits around them. The offsets on either side of 0xD04 are enough to test address decoding. The same-cycle collisions between acknowledge, NMI raise and software set or clear can each be set up with a single strobe.

// File: rtl/exc_pend_pkg.sv
package exc_pend_pkg;
  // Read/write bit positions software relies on
  localparam int unsigned NMI_SET_BIT  = 31;
  localparam int unsigned SVC_SET_BIT  = 28;
  localparam int unsigned SVC_CLR_BIT  = 27;
  localparam int unsigned TICK_SET_BIT = 26;
  localparam int unsigned TICK_CLR_BIT = 25;
  localparam int unsigned DBG_BIT      = 23;
  localparam int unsigned PEND_LSB     = 12;
  localparam int unsigned ACT_LSB      = 0;

  // Flag indices
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned IDX_NMI   = 0;
  localparam int unsigned IDX_SVC   = 1;
  localparam int unsigned IDX_TICK  = 2;

  typedef struct packed {
    logic set;
    logic clr;
  } flag_cmd_t;
endpackage

// File: rtl/exc_pend_bus_dec.sv
module exc_pend_bus_dec
  import exc_pend_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hD04
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic              priv,
  output logic              rd_ok,
  output logic              priv_fault,
  output flag_cmd_t         cmd [NUM_FLAGS]
);
  logic hit;
  logic wr_ok;
  logic unused_wdata;

  assign hit        = (addr == REG_OFFSET);
  assign wr_ok      = wr & priv & hit;
  assign rd_ok      = rd & priv & hit;
  assign priv_fault = (wr | rd) & ~priv;

  always_comb begin
    cmd[IDX_NMI].set  = wr_ok & wdata[NMI_SET_BIT];
    cmd[IDX_NMI].clr  = 1'b0;
    cmd[IDX_SVC].set  = wr_ok & wdata[SVC_SET_BIT];
    cmd[IDX_SVC].clr  = wr_ok & wdata[SVC_CLR_BIT];
    cmd[IDX_TICK].set = wr_ok & wdata[TICK_SET_BIT];
    cmd[IDX_TICK].clr = wr_ok & wdata[TICK_CLR_BIT];
  end

  assign unused_wdata = ^wdata;
endmodule

// File: rtl/exc_pend_flag.sv
module exc_pend_flag
  import exc_pend_pkg::*;
#(
  parameter bit HW_SET_EN = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  flag_cmd_t cmd,
  input  logic      ack,
  input  logic      hw_set,
  output logic      pend
);
  logic pend_q;
  logic pend_d;
  logic pend_en;
  logic hw_set_eff;

  assign hw_set_eff = HW_SET_EN ? hw_set : 1'b0;

  // Priority: hardware raise, then acknowledge, then software set/clear
  always_comb begin
    pend_d  = pend_q;
    pend_en = hw_set_eff | ack | (cmd.set ^ cmd.clr);
    if (hw_set_eff)
      pend_d = 1'b1;
    else if (ack)
      pend_d = 1'b0;
    else if (cmd.set && !cmd.clr)
      pend_d = 1'b1;
    else if (cmd.clr && !cmd.set)
      pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else if (pend_en)
      pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/exc_pend_rdmux.sv
module exc_pend_rdmux
  import exc_pend_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VEC_W  = 9
) (
  input  logic             rd_ok,
  input  logic             nmi,
  input  logic             svc,
  input  logic             tick,
  input  logic             dbg_mode,
  input  logic             dbg_irq,
  input  logic [VEC_W-1:0] act_vec,
  input  logic [VEC_W-1:0] pend_vec,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word                        = '0;
    word[NMI_SET_BIT]           = nmi;
    word[SVC_SET_BIT]           = svc;
    word[TICK_SET_BIT]          = tick;
    word[DBG_BIT]               = dbg_mode & dbg_irq;
    word[PEND_LSB +: VEC_W]     = pend_vec;
    word[ACT_LSB +: VEC_W]      = act_vec;
  end

  assign rdata = rd_ok ? word : '0;
endmodule

// File: rtl/exc_pend_reg.sv
module exc_pend_reg
  import exc_pend_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned VEC_W      = 9,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hD04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_priv,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              nmi_raise,
  input  logic              nmi_ack,
  input  logic              svc_ack,
  input  logic              tick_ack,
  input  logic              dbg_mode,
  input  logic              dbg_irq,
  input  logic [VEC_W-1:0]  act_vec,
  input  logic [VEC_W-1:0]  pend_vec,
  output logic              nmi_pend,
  output logic              svc_pend,
  output logic              tick_pend
);
  localparam int unsigned SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= '0;
    else
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  // Bus decode
  logic      rd_ok;
  logic      priv_fault;
  flag_cmd_t cmd [NUM_FLAGS];

  exc_pend_bus_dec #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .REG_OFFSET (REG_OFFSET)
  ) u_dec (
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .wr         (bus_wr),
    .rd         (bus_rd),
    .priv       (bus_priv),
    .rd_ok      (rd_ok),
    .priv_fault (priv_fault),
    .cmd        (cmd)
  );

  // Pending flags
  logic [NUM_FLAGS-1:0] ack_vec;
  logic [NUM_FLAGS-1:0] hw_set_vec;
  logic [NUM_FLAGS-1:0] pend_q;

  assign ack_vec    = {tick_ack, svc_ack, nmi_ack};
  assign hw_set_vec = {1'b0, 1'b0, nmi_raise};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    exc_pend_flag #(
      .HW_SET_EN (i == IDX_NMI)
    ) u_flag (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .cmd    (cmd[i]),
      .ack    (ack_vec[i]),
      .hw_set (hw_set_vec[i]),
      .pend   (pend_q[i])
    );
  end

  assign nmi_pend  = pend_q[IDX_NMI];
  assign svc_pend  = pend_q[IDX_SVC];
  assign tick_pend = pend_q[IDX_TICK];

  // Read path
  exc_pend_rdmux #(
    .DATA_W (DATA_W),
    .VEC_W  (VEC_W)
  ) u_rdmux (
    .rd_ok    (rd_ok),
    .nmi      (pend_q[IDX_NMI]),
    .svc      (pend_q[IDX_SVC]),
    .tick     (pend_q[IDX_TICK]),
    .dbg_mode (dbg_mode),
    .dbg_irq  (dbg_irq),
    .act_vec  (act_vec),
    .pend_vec (pend_vec),
    .rdata    (bus_rdata)
  );

  // Error pulse: next-state and register
  logic err_q;
  logic err_d;
  logic err_en;

  always_comb begin
    err_d  = priv_fault;
    err_en = priv_fault | err_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)
      err_q <= 1'b0;
    else if (err_en)
      err_q <= err_d;
  end

  assign bus_err = err_q;
endmodule

// File: rtl/exc_pend_chk.sv
module exc_pend_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hD04
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_priv,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic              nmi_raise,
  input logic              nmi_ack,
  input logic              svc_ack,
  input logic              tick_ack,
  input logic              nmi_pend,
  input logic              svc_pend,
  input logic              tick_pend
);
  logic any_hw;
  assign any_hw = nmi_raise | nmi_ack | svc_ack | tick_ack;

  // R6
  nmi_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_raise |=> nmi_pend);

  // R6
  nmi_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack && !nmi_raise) |=> !nmi_pend);

  // R7
  svc_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ack |=> !svc_pend);

  // R7
  tick_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_ack |=> !tick_pend);

  // R3
  svc_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_priv && bus_addr == REG_OFFSET && bus_wdata[28] && bus_wdata[27] && !svc_ack)
    |=> svc_pend == $past(svc_pend));

  // R5
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[30:29] == 2'b00 && bus_rdata[27] == 1'b0 && bus_rdata[25:24] == 2'b00);

  // R10
  offset_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != REG_OFFSET && !any_hw) |=> $stable({nmi_pend, svc_pend, tick_pend}));

  // R11
  priv_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_priv) |-> bus_rdata == '0);

  // R11
  priv_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !bus_priv) |=> bus_err);

  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((bus_rd || bus_wr) && !bus_priv) |=> !bus_err);
endmodule

bind exc_pend_reg exc_pend_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .REG_OFFSET (REG_OFFSET)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_priv  (bus_priv),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .nmi_raise (nmi_raise),
  .nmi_ack   (nmi_ack),
  .svc_ack   (svc_ack),
  .tick_ack  (tick_ack),
  .nmi_pend  (nmi_pend),
  .svc_pend  (svc_pend),
  .tick_pend (tick_pend)
);

// File: tb/tb_exc_pend_reg.sv
module tb_exc_pend_reg;
  localparam logic [11:0] OFF = 12'hD04;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr, bus_rd, bus_priv;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        nmi_raise, nmi_ack, svc_ack, tick_ack;
  logic        dbg_mode, dbg_irq;
  logic [8:0]  act_vec, pend_vec;
  logic        nmi_pend, svc_pend, tick_pend;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  exc_pend_reg dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .nmi_raise(nmi_raise), .nmi_ack(nmi_ack), .svc_ack(svc_ack),
    .tick_ack(tick_ack), .dbg_mode(dbg_mode), .dbg_irq(dbg_irq), .act_vec(act_vec),
    .pend_vec(pend_vec), .nmi_pend(nmi_pend), .svc_pend(svc_pend), .tick_pend(tick_pend)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic n, input logic s, input logic t);
    logic [31:0] w;
    w = '0;
    w[31] = n; w[28] = s; w[26] = t;
    w[23] = dbg_mode & dbg_irq;
    w[20:12] = pend_vec;
    w[8:0] = act_vec;
    return w;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic p);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_priv = p;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; bus_priv = 1'b1;
  endtask

  task automatic rd(input logic [11:0] a, input logic p, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_priv = p;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_priv = 1'b1;
  endtask

  task automatic pulse(input logic n_r, input logic n_a, input logic s_a, input logic t_a,
                       input logic [31:0] d);
    @(negedge clk);
    nmi_raise = n_r; nmi_ack = n_a; svc_ack = s_a; tick_ack = t_a;
    bus_addr = OFF; bus_wdata = d; bus_wr = (d != 0); bus_priv = 1'b1;
    @(negedge clk);
    nmi_raise = 0; nmi_ack = 0; svc_ack = 0; tick_ack = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk({29'd0, nmi_pend, svc_pend, tick_pend}, 32'd0, "R1 pend flags");
    chk({31'd0, bus_err}, 32'd0, "R1 bus_err");
    rd(OFF, 1'b1, d);
    chk(d, 32'd0, "R1 read after reset");
  endtask

  task automatic t_nmi();
    logic [31:0] d;
    wr(OFF, 32'h8000_0000, 1'b1);
    chk({31'd0, nmi_pend}, 32'd1, "R2 nmi set");
    rd(OFF, 1'b1, d);
    chk(d, word(1, 0, 0), "R2 nmi readback");
    pulse(0, 1, 0, 0, 32'd0);
    chk({31'd0, nmi_pend}, 32'd0, "R6 nmi ack clears");
    pulse(1, 1, 0, 0, 32'd0);
    chk({31'd0, nmi_pend}, 32'd1, "R6 raise beats ack");
    pulse(0, 1, 0, 0, 32'd0);
    pulse(0, 1, 0, 0, 32'h8000_0000);
    chk({31'd0, nmi_pend}, 32'd0, "R6 ack beats sw set");
  endtask

  task automatic t_svc();
    wr(OFF, 32'h1000_0000, 1'b1);
    chk({31'd0, svc_pend}, 32'd1, "R3 svc set");
    wr(OFF, 32'h1800_0000, 1'b1);
    chk({31'd0, svc_pend}, 32'd1, "R3 both keeps 1");
    wr(OFF, 32'h0800_0000, 1'b1);
    chk({31'd0, svc_pend}, 32'd0, "R3 svc clear");
    wr(OFF, 32'h1800_0000, 1'b1);
    chk({31'd0, svc_pend}, 32'd0, "R3 both keeps 0");
    pulse(0, 0, 1, 0, 32'h1000_0000);
    chk({31'd0, svc_pend}, 32'd0, "R7 svc ack beats set");
    wr(OFF, 32'h1000_0000, 1'b1);
    pulse(0, 0, 1, 0, 32'd0);
    chk({31'd0, svc_pend}, 32'd0, "R7 svc ack clears");
  endtask

  task automatic t_tick();
    wr(OFF, 32'h0400_0000, 1'b1);
    chk({31'd0, tick_pend}, 32'd1, "R4 tick set");
    wr(OFF, 32'h0600_0000, 1'b1);
    chk({31'd0, tick_pend}, 32'd1, "R4 both keeps 1");
    wr(OFF, 32'h0200_0000, 1'b1);
    chk({31'd0, tick_pend}, 32'd0, "R4 tick clear");
    wr(OFF, 32'h0600_0000, 1'b1);
    chk({31'd0, tick_pend}, 32'd0, "R4 both keeps 0");
    pulse(0, 0, 0, 1, 32'h0400_0000);
    chk({31'd0, tick_pend}, 32'd0, "R7 tick ack beats set");
  endtask

  task automatic t_rsvd();
    logic [31:0] d;
    wr(OFF, 32'h1400_0000, 1'b1);
    rd(OFF, 1'b1, d);
    chk(d & 32'h6B60_0E00, 32'd0, "R5 write-only and reserved bits");
    chk(d, word(0, 1, 1), "R5 full word");
  endtask

  task automatic t_dbg();
    logic [31:0] d;
    dbg_irq = 1'b1; dbg_mode = 1'b0;
    rd(OFF, 1'b1, d);
    chk({31'd0, d[23]}, 32'd0, "R8 debug off");
    dbg_mode = 1'b1;
    rd(OFF, 1'b1, d);
    chk({31'd0, d[23]}, 32'd1, "R8 debug on");
    dbg_mode = 1'b0; dbg_irq = 1'b0;
  endtask

  task automatic t_vec();
    logic [31:0] d;
    act_vec = 9'h1FF; pend_vec = 9'h0A5;
    rd(OFF, 1'b1, d);
    chk(d & 32'h001F_FFFF, 32'h000A_51FF, "R9 vectors");
    act_vec = 9'h003; pend_vec = 9'h1FF;
    rd(OFF, 1'b1, d);
    chk(d & 32'h001F_FFFF, 32'h001F_F003, "R9 vectors swapped");
    act_vec = '0; pend_vec = '0;
  endtask

  task automatic t_offset();
    logic [31:0] d;
    wr(OFF, 32'h0A00_0000, 1'b1);
    wr(12'hD00, 32'h1400_0000, 1'b1);
    wr(12'hD08, 32'h1400_0000, 1'b1);
    chk({30'd0, svc_pend, tick_pend}, 32'd0, "R10 other offset write ignored");
    wr(OFF, 32'h1000_0000, 1'b1);
    rd(12'hD08, 1'b1, d);
    chk(d, 32'd0, "R10 other offset reads 0");
    @(negedge clk); bus_addr = OFF; bus_rd = 1'b0;
    #2 chk(bus_rdata, 32'd0, "R10 no strobe reads 0");
  endtask

  task automatic t_priv();
    logic [31:0] d;
    wr(OFF, 32'h0400_0000, 1'b0);
    chk({31'd0, tick_pend}, 32'd0, "R11 unprivileged write ignored");
    chk({31'd0, bus_err}, 32'd1, "R11 err after write");
    @(negedge clk);
    chk({31'd0, bus_err}, 32'd0, "R11 err one cycle");
    rd(OFF, 1'b0, d);
    chk(d, 32'd0, "R11 unprivileged read 0");
    chk({31'd0, bus_err}, 32'd1, "R11 err after read");
    chk({31'd0, svc_pend}, 32'd1, "R11 svc kept");
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_wr = 0; bus_rd = 0; bus_priv = 1;
    nmi_raise = 0; nmi_ack = 0; svc_ack = 0; tick_ack = 0;
    dbg_mode = 0; dbg_irq = 0; act_vec = '0; pend_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_nmi();
    t_svc();
    t_tick();
    t_rsvd();
    t_dbg();
    t_vec();
    t_offset();
    t_priv();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule